// File: doc/BRIEF.md
# Outbound Address Translator with Viewport Programming

This block sits on the request path of a PCIe root port. It turns a 64-bit address from the processor side into a bus address and a transaction kind. It does this with a small set of outbound windows. Each window has a base, an inclusive last-byte limit, a target, a transaction type and an enable. On every request, all enabled windows are compared in parallel. The lowest-numbered window that matches rebases the address onto its target and supplies its type. A request that matches no window leaves unchanged, with a miss flag raised.

Software never addresses a window directly. It first writes a selector register that names a direction and a window index. Every later access to the shared window registers then lands on the window that the selector names. When the selector names the inbound direction, or an index that does not exist, the shared registers are dead: writes are dropped and reads return zero. Translation is combinational from the stored window state, so a register write steers requests from the following clock cycle.

Top module: `ob_xlate`

## Requirements
- R1: The selector register at offset 0x900 stores the direction in bit 31 (1 = inbound, 0 = outbound) and the window index in bits 7:0. It reads back the stored value, and all other bits read as zero.
- R2: While the selector names an existing outbound window, the shared registers read back that window's stored value. Type sits at 0x904 in bits 2:0. Enable sits at 0x908 in bit 31, with a stored-only BAR-mode bit in bit 30. The base low word is at 0x90C, the base high word at 0x910, the limit low word at 0x914, the target low word at 0x918 and the target high word at 0x91C. Unused bits and unknown offsets read as zero.
- R3: While the selector names the inbound direction or an index at or above NREG, writes to the shared registers change no window, and reads of the shared registers return zero.
- R4: A window matches when its enable is set, the request's bits 63:32 equal the base high word, and the request's bits 31:0 lie between the base low word and the limit, with both ends included.
- R5: On a match, the output address is the 64-bit target plus the request address minus the 64-bit base.
- R6: On a match, the output type is the window's type code: memory 0, I/O 2, configuration type 0 is 4, configuration type 1 is 5.
- R7: When several windows match, the window with the lowest index supplies the translation, and its index is output.
- R8: When no window matches, the output address equals the request, the type is 0, the region index is 0 and the miss flag is 1.
- R9: A register write changes translation from the cycle after the clock edge that captures it. Before that edge, translation uses the old value.
- R10: After reset, every window is disabled with all fields zero, the selector reads zero, and every request misses.
- R11: For a configuration window, the target low word carries the bus number in bits 31:24, the device number in bits 23:19 and the function number in bits 18:16. A request at the window base yields exactly those fields in the output address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_addr | input | 64 | Processor-side request address |
| xl_addr | output | 64 | Translated bus address |
| xl_type | output | 3 | Transaction type code |
| xl_miss | output | 1 | No enabled window matched |
| xl_region | output | RIDX_W | Index of the winning window |

## Verification
The assertions check four things on every cycle. A reported hit always lies inside an enabled window's inclusive range. No lower-indexed window matched when a higher one won. A miss passes the request through with type 0. A write issued while the selector is dead leaves every window unchanged.

Some behaviours can only be shown by the bench's scenarios. These are the exact rebased address arithmetic, the readback at each register offset, the one-cycle gap between a write and its effect, the type codes, and the bus/device/function placement. The bench shows them by sweeping addresses across every window edge under several window layouts.

// File: rtl/ob_xlate.sv
module ob_xlate #(
  parameter int NREG = 2,
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [63:0]       req_addr,
  output logic [63:0]       xl_addr,
  output logic [2:0]        xl_type,
  output logic              xl_miss,
  output logic [RIDX_W-1:0] xl_region
);
  localparam logic [11:0] A_SEL = 12'h900, A_TYP = 12'h904, A_CTL = 12'h908,
                          A_BLO = 12'h90C, A_BHI = 12'h910, A_LIM = 12'h914,
                          A_TLO = 12'h918, A_THI = 12'h91C;

  logic       sel_in;
  logic [7:0] sel_idx;
  logic [2:0]  w_typ [NREG];
  logic        w_en  [NREG];
  logic        w_bar [NREG];
  logic [31:0] w_blo [NREG];
  logic [31:0] w_bhi [NREG];
  logic [31:0] w_lim [NREG];
  logic [31:0] w_tlo [NREG];
  logic [31:0] w_thi [NREG];
  logic [NREG-1:0] hit;
  logic [RIDX_W-1:0] win;

  wire sel_ok = !sel_in && (sel_idx < 8'(NREG));
  wire [RIDX_W-1:0] sel = sel_idx[RIDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_in  <= 1'b0;
      sel_idx <= '0;
    end else if (cfg_we && cfg_addr == A_SEL) begin
      sel_in  <= cfg_wdata[31];
      sel_idx <= cfg_wdata[7:0];
    end

  for (genvar k = 0; k < NREG; k++) begin : g_win
    wire wr = cfg_we && sel_ok && (sel_idx == 8'(k));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        w_typ[k] <= '0; w_en[k] <= 1'b0; w_bar[k] <= 1'b0;
        w_blo[k] <= '0; w_bhi[k] <= '0; w_lim[k] <= '0;
        w_tlo[k] <= '0; w_thi[k] <= '0;
      end else if (wr) begin
        case (cfg_addr)
          A_TYP: w_typ[k] <= cfg_wdata[2:0];
          A_CTL: begin w_en[k] <= cfg_wdata[31]; w_bar[k] <= cfg_wdata[30]; end
          A_BLO: w_blo[k] <= cfg_wdata;
          A_BHI: w_bhi[k] <= cfg_wdata;
          A_LIM: w_lim[k] <= cfg_wdata;
          A_TLO: w_tlo[k] <= cfg_wdata;
          A_THI: w_thi[k] <= cfg_wdata;
          default: ;
        endcase
      end

    assign hit[k] = w_en[k] && (req_addr[63:32] == w_bhi[k]) &&
                    (req_addr[31:0] >= w_blo[k]) && (req_addr[31:0] <= w_lim[k]);

    // R7
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xl_miss && xl_region > RIDX_W'(k)) |-> !hit[k]);

    // R3
    dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !sel_ok && cfg_addr != A_SEL) |=>
        ($stable(w_blo[k]) && $stable(w_bhi[k]) && $stable(w_lim[k]) &&
         $stable(w_tlo[k]) && $stable(w_thi[k]) && $stable(w_typ[k]) &&
         $stable(w_en[k])));
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_SEL) cfg_rdata = {sel_in, 23'b0, sel_idx};
    else if (sel_ok)
      case (cfg_addr)
        A_TYP: cfg_rdata = {29'b0, w_typ[sel]};
        A_CTL: cfg_rdata = {w_en[sel], w_bar[sel], 30'b0};
        A_BLO: cfg_rdata = w_blo[sel];
        A_BHI: cfg_rdata = w_bhi[sel];
        A_LIM: cfg_rdata = w_lim[sel];
        A_TLO: cfg_rdata = w_tlo[sel];
        A_THI: cfg_rdata = w_thi[sel];
        default: cfg_rdata = '0;
      endcase
  end

  always_comb begin
    win = '0;
    for (int k = NREG - 1; k >= 0; k--)
      if (hit[k]) win = RIDX_W'(k);
  end

  assign xl_miss   = ~|hit;
  assign xl_region = win;
  assign xl_type   = xl_miss ? 3'd0 : w_typ[win];
  assign xl_addr   = xl_miss ? req_addr
                   : {w_thi[win], w_tlo[win]} + (req_addr - {w_bhi[win], w_blo[win]});

  // R4
  hit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_miss |-> (w_en[xl_region] && req_addr[63:32] == w_bhi[xl_region] &&
                  req_addr[31:0] >= w_blo[xl_region] && req_addr[31:0] <= w_lim[xl_region]));

  // R8
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |-> (xl_addr == req_addr && xl_type == 3'd0 && xl_region == '0));
endmodule

// File: tb/ob_xlate_bench.sv
module ob_xlate_bench;
  localparam int NREG = 2;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [63:0] req_addr = '0, xl_addr;
  logic [2:0]  xl_type;
  logic        xl_miss;
  logic [0:0]  xl_region;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [2:0]  m_typ [NREG];
  logic        m_en  [NREG];
  logic [31:0] m_blo [NREG], m_bhi [NREG], m_lim [NREG], m_tlo [NREG], m_thi [NREG];

  ob_xlate #(.NREG(NREG)) u_ob_xlate (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic prog(input int k, input logic [2:0] t, input logic en,
                      input logic [31:0] bhi, blo, lim, thi, tlo);
    wr(12'h900, 32'(k));
    wr(12'h904, 32'(t));
    wr(12'h90C, blo); wr(12'h910, bhi); wr(12'h914, lim);
    wr(12'h918, tlo); wr(12'h91C, thi);
    wr(12'h908, {en, 31'b0});
    m_typ[k] = t; m_en[k] = en; m_bhi[k] = bhi; m_blo[k] = blo;
    m_lim[k] = lim; m_thi[k] = thi; m_tlo[k] = tlo;
  endtask

  task automatic xl_chk(input logic [63:0] a, input string req);
    logic [63:0] ea = a;
    logic [2:0]  et = 3'd0;
    logic        em = 1'b1;
    logic        er = 1'b0;
    for (int k = NREG - 1; k >= 0; k--)
      if (m_en[k] && a[63:32] == m_bhi[k] && a[31:0] >= m_blo[k] && a[31:0] <= m_lim[k]) begin
        em = 1'b0; er = 1'(k); et = m_typ[k];
        ea = {m_thi[k], m_tlo[k]} + a - {m_bhi[k], m_blo[k]};
      end
    req_addr = a;
    #1;
    chk(xl_addr == ea && xl_type == et && xl_miss == em && xl_region == er, req,
        {xl_addr[59:0], xl_miss, xl_type}, {ea[59:0], em, et});
  endtask

  task automatic sweep(input string req);
    logic [31:0] lows [11] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001,
      32'h80EF_FFFF, 32'h80F0_0000, 32'h80FF_FFFF, 32'h8100_0000, 32'h8FFF_FFFF,
      32'h9000_0000, 32'hFFFF_FFFF};
    for (int u = 15; u <= 17; u++)
      foreach (lows[i]) xl_chk({32'(u), lows[i]}, req);
    for (int d = -32; d < 32; d++) xl_chk({32'h10, 32'h80F0_0000 + 32'(d)}, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) begin
      m_typ[k] = 0; m_en[k] = 0; m_bhi[k] = 0; m_blo[k] = 0;
      m_lim[k] = 0; m_thi[k] = 0; m_tlo[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_chk(12'h900, 32'h0, "R10 selector");
    rd_chk(12'h908, 32'h0, "R10 enable");
    rd_chk(12'h914, 32'h0, "R10 limit");
    xl_chk(64'h0, "R10 miss at zero");
    xl_chk(64'h0000_0010_8000_0000, "R10 miss");

    // R1 selector readback
    wr(12'h900, 32'h8000_00A5);
    rd_chk(12'h900, 32'h8000_00A5, "R1 selector inbound");
    wr(12'h900, 32'h7FFF_FF01);
    rd_chk(12'h900, 32'h0000_0001, "R1 selector masked");

    // program windows: region1 cfg type 0, region0 memory left disabled
    prog(1, 3'd4, 1'b1, 32'h10, 32'h80F0_0000, 32'h8FFF_FFFF, 32'h0, 32'h032A_0000);
    prog(0, 3'd0, 1'b0, 32'h10, 32'h8000_0000, 32'h80FF_FFFF, 32'h2, 32'h4000_0000);
    sweep("R4 R5 R8 one window");

    // R11 bus/device/function fields
    xl_chk(64'h0000_0010_80F0_0000, "R11 base");
    chk(xl_addr[31:24] == 8'd3 && xl_addr[23:19] == 5'd5 && xl_addr[18:16] == 3'd2,
        "R11 fields", 64'(xl_addr[31:16]), 64'h032A);

    // R9 enable of region0 visible only after the capturing edge
    wr(12'h900, 32'h0);
    req_addr = 64'h0000_0010_8000_0010;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h908; cfg_wdata = 32'h8000_0000;
    #1;
    chk(xl_miss == 1'b1, "R9 before edge", 64'(xl_miss), 64'h1);
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[0] = 1'b1;
    #1;
    chk(xl_miss == 1'b0 && xl_addr == 64'h0000_0002_4000_0010, "R9 after edge",
        xl_addr, 64'h0000_0002_4000_0010);
    sweep("R7 overlap priority");

    // R2 readback for both windows
    wr(12'h900, 32'h0);
    wr(12'h908, 32'hC000_0000);
    rd_chk(12'h908, 32'hC000_0000, "R2 ctl with bar");
    rd_chk(12'h904, 32'h0, "R2 type r0");
    rd_chk(12'h90C, 32'h8000_0000, "R2 blo r0");
    rd_chk(12'h910, 32'h10, "R2 bhi r0");
    rd_chk(12'h914, 32'h80FF_FFFF, "R2 lim r0");
    rd_chk(12'h918, 32'h4000_0000, "R2 tlo r0");
    rd_chk(12'h91C, 32'h2, "R2 thi r0");
    rd_chk(12'h920, 32'h0, "R2 unknown offset");
    wr(12'h900, 32'h1);
    rd_chk(12'h904, 32'h4, "R2 type r1");
    rd_chk(12'h918, 32'h032A_0000, "R2 tlo r1");

    // R3 dead selector: inbound and out-of-range index
    wr(12'h900, 32'h8000_0000);
    wr(12'h90C, 32'h1234_5678);
    wr(12'h908, 32'h0);
    rd_chk(12'h90C, 32'h0, "R3 inbound read zero");
    xl_chk(64'h0000_0010_8000_0000, "R3 inbound write ignored");
    wr(12'h900, 32'h5);
    wr(12'h914, 32'h0);
    rd_chk(12'h914, 32'h0, "R3 index read zero");
    wr(12'h900, 32'h0);
    rd_chk(12'h90C, 32'h8000_0000, "R3 r0 blo kept");
    rd_chk(12'h914, 32'h80FF_FFFF, "R3 r0 lim kept");
    wr(12'h900, 32'h1);
    rd_chk(12'h914, 32'h8FFF_FFFF, "R3 r1 lim kept");

    // R6 type codes on region1 (region0 disabled so region1 wins)
    prog(0, 3'd0, 1'b0, 32'h10, 32'h8000_0000, 32'h80FF_FFFF, 32'h2, 32'h4000_0000);
    begin
      logic [2:0] codes [4] = '{3'd0, 3'd2, 3'd4, 3'd5};
      foreach (codes[i]) begin
        wr(12'h900, 32'h1);
        wr(12'h904, 32'(codes[i]));
        m_typ[1] = codes[i];
        xl_chk(64'h0000_0010_8800_0000, "R6 type code");
      end
    end

    // R5 wide target with carry into upper word
    prog(1, 3'd5, 1'b1, 32'h0, 32'h0000_1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_F000);
    sweep("R5 carry");
    xl_chk(64'h0000_0000_FFFF_FFFF, "R5 top of range");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule